// File: doc/BRIEF.md
# Floating-Point Leading-Zero Normaliser

This purely combinational block brings a floating-point significand into normal form. It shifts the significand toward its top bit until a 1 occupies the top position, and it lowers the exponent by the same number of places. The significand arrives with three low extension bits attached: sticky in bit 0, round in bit 1 and guard in bit 2. These bits move up with the rest of the value, so precision held below the result's least significant bit is kept.

The shift has a ceiling. The caller supplies `limit`, the headroom between the current exponent and the smallest normal exponent. The block never shifts further than that headroom, so a value that cannot be fully normalised leaves with the exponent set exactly at the floor. When the sticky bit is set, the positions vacated at the bottom are filled with ones rather than zeros. This keeps the "something was lost below" information for a later rounding stage. Significand width and exponent width are independent parameters.

Top module: `fp_lz_norm`

## Requirements
- R1: `m_in` bit 0 is sticky, bit 1 is round and bit 2 is guard. Bits W-1..3 are the significand. All of them shift together, so a guard bit at position 2 lands at position 2+s after a shift of s.
- R2: The shift s is the smaller of the leading-zero count of `m_in` (counted from bit W-1 downward) and `limit`. Then `m_out[W-1:s]` equals `m_in[W-1-s:0]`.
- R3: `e_out` equals `e_in - s`, computed in the signed exponent width.
- R4: When `m_in` is nonzero and its leading-zero count does not exceed a positive `limit`, `m_out[W-1]` is 1.
- R5: The exponent never drops by more than a positive `limit`.
- R6: When `m_in[0]` is 1, the s vacated low bits of `m_out` are all 1. When `m_in[0]` is 0, they are all 0.
- R7: When `limit` is zero or negative, `m_out` equals `m_in` and `e_out` equals `e_in`.
- R8: When `m_in[W-1]` is already 1, `m_out` equals `m_in` and `e_out` equals `e_in`.
- R9: An all-zero `m_in` gives an all-zero `m_out`, and the exponent falls by the smaller of W and `limit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_in | input | W | Significand with guard, round and sticky in bits 2..0 |
| e_in | input | EW (signed) | Exponent before normalisation |
| limit | input | EW (signed) | Headroom above the minimum normal exponent |
| m_out | output | W | Normalised significand with shifted extension bits |
| e_out | output | EW (signed) | Exponent lowered by the applied shift |

## Verification
Immediate assertions inside the design are evaluated whenever the inputs change. They check that the count of set bits grows exactly by the sticky fill, that the exponent drop stays within the headroom, that the top bit is set whenever the headroom allowed full normalisation, and that a non-positive limit leaves both outputs untouched. The exact placement of guard and round bits, all-zero inputs, and exact equality of the shifted value and exponent with the expected result can only be shown by the bench's scenarios. The bench compares against a reference model that shifts one place at a time.

// File: rtl/fp_lz_norm.sv
module fp_lz_norm #(
  parameter int W  = 27,
  parameter int EW = 10
) (
  input  logic [W-1:0]         m_in,
  input  logic signed [EW-1:0] e_in,
  input  logic signed [EW-1:0] limit,
  output logic [W-1:0]         m_out,
  output logic signed [EW-1:0] e_out
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0]        lzc;
  logic signed [EW:0]   lz_ext, lim_ext, sh_w;
  logic [CW-1:0]        sh;
  logic [W:0]           fill;

  always_comb begin
    lzc = CW'(W);
    for (int i = 0; i < W; i++)
      if (m_in[i]) lzc = CW'(W - 1 - i);
  end

  assign lz_ext  = $signed({{(EW + 1 - CW){1'b0}}, lzc});
  assign lim_ext = $signed({limit[EW-1], limit});
  assign sh_w    = (lim_ext <= 0) ? '0 : ((lim_ext < lz_ext) ? lim_ext : lz_ext);
  assign sh      = sh_w[CW-1:0];

  assign fill  = ({{W{1'b0}}, 1'b1} << sh) - 1'b1;
  assign m_out = (m_in << sh) | (m_in[0] ? fill[W-1:0] : '0);
  assign e_out = e_in - $signed({{(EW - CW){1'b0}}, sh});

  logic [EW-1:0] drop;
  assign drop = e_in - e_out;

  always_comb begin
    AST_FILL_COUNT: assert ($countones(m_out) == $countones(m_in) + (m_in[0] ? int'(sh) : 0)); // R6
    if (limit > 0) begin
      AST_EXP_FLOOR: assert (drop <= limit[EW-1:0]); // R5
      if (m_in != '0 && lz_ext <= lim_ext)
        AST_MSB_SET: assert (m_out[W-1]); // R4
    end else begin
      AST_NO_SHIFT: assert (m_out == m_in && e_out == e_in); // R7
    end
  end
endmodule

// File: tb/fp_lz_norm_tb_top.sv
module fp_lz_norm_tb_top;
  localparam int W  = 27;
  localparam int EW = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0]         m_in = '0;
  logic signed [EW-1:0] e_in = '0;
  logic signed [EW-1:0] limit = '0;
  logic [W-1:0]         m_out;
  logic signed [EW-1:0] e_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  fp_lz_norm #(.W(W), .EW(EW)) dut_i (
    .m_in(m_in), .e_in(e_in), .limit(limit), .m_out(m_out), .e_out(e_out));

  function automatic int ref_shift(logic [W-1:0] m, logic signed [EW-1:0] lim);
    int s = 0;
    while (s < int'(lim) && s < W && !m[W-1]) begin
      m = m << 1;
      s++;
    end
    return s;
  endfunction

  function automatic logic [W-1:0] ref_m(logic [W-1:0] m, int s);
    logic stk = m[0];
    for (int k = 0; k < s; k++) m = {m[W-2:0], stk};
    return m;
  endfunction

  task automatic check(string req, logic [W-1:0] m, logic signed [EW-1:0] e,
                       logic signed [EW-1:0] lim);
    int s;
    logic [W-1:0] xm;
    logic signed [EW-1:0] xe;
    @(posedge clk);
    m_in = m; e_in = e; limit = lim;
    @(negedge clk);
    s  = ref_shift(m, lim);
    xm = ref_m(m, s);
    xe = e - EW'(s);
    n_chk++;
    if (m_out !== xm || e_out !== xe) begin
      n_fail++;
      $display("FAIL %s: m_out=%h e_out=%0d expected m_out=%h e_out=%0d", req, m_out, e_out, xm, xe);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    check("R8 msb already set", 27'h4000001, 10'sd50, 10'sd20);
    check("R2 single lsb sticky R6", 27'h0000001, 10'sd100, 10'sd60);
    check("R9 all zero", 27'h0, 10'sd100, 10'sd60);
    check("R9 all zero clamp", 27'h0, 10'sd10, 10'sd5);
    check("R7 zero limit", 27'h0000F03, 10'sd3, 10'sd0);
    check("R7 negative limit", 27'h0000F03, -10'sd4, -10'sd7);
    check("R5 limit below lzc", 27'h0000100, 10'sd40, 10'sd4);
    check("R6 sticky large shift", 27'h0000041, 10'sd200, 10'sd100);
    check("R1 guard round move", 27'h0000006, 10'sd90, 10'sd80);
    check("R4 exact limit", 27'h0100000, 10'sd30, 10'sd6);
    check("R3 negative exponent", 27'h0002000, -10'sd100, 10'sd26);
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] m;
      m = W'($urandom >> ($urandom % 32));
      check("R2 R3 random", m, EW'(int'($urandom % 300) - 100), EW'(int'($urandom % 50) - 8));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule